// File: doc/BRIEF.md
# Nearest-Level Gate Sequencer for a Binary-Weighted Fifteen-Level Inverter

This block turns a stream of signed reference samples into gate commands for a staircase inverter. The inverter has three DC sources weighted one, two and four units, followed by a polarity bridge. Each sample arrives with a one-cycle valid strobe. The block rounds the sample to the nearest whole number of steps, where the step size is programmable. It saturates the result at seven steps of either sign, so the available levels run from -7 to +7. It then looks up the ten switch commands for that level: one insert switch and one bypass switch per source, plus the four bridge switches.

A level's magnitude is formed by inserting the sources whose weights add up to it and bypassing the rest. Zero is produced by bypassing all three sources, with the bridge left off. The sign comes only from the bridge, which turns on one diagonal pair for positive levels and the other pair for negative levels. When a new switch pattern both opens some switches and closes others, the switches being opened go off first. The block then holds a gap of programmable length before the new ones close. A signed status output reports the level whose pattern is fully applied.

Top module: `mli_gate_ctrl`

## Requirements
- R1: On a strobe, the chosen magnitude is the number of j in 1..7 with 2*|ref_smp| >= (2j-1)*step_size. This is nearest-step rounding with ties going away from zero. The sign follows bit 15 of ref_smp. A step_size of zero selects magnitude 7.
- R2: The applied level stays within -7..+7, and level_now never shows the code 4'b1000.
- R3: For level magnitude k, bit i of src_ins equals bit i of k, and src_byp is the bitwise inverse of k over the three sources. Bit 0 is the unit source, bit 1 the double source and bit 2 the quadruple source.
- R4: hb_gate bits are [0]=leg A high, [1]=leg B high, [2]=leg A low, [3]=leg B low. Positive levels give 4'b1001, negative levels give 4'b0110, and zero gives 4'b0000.
- R5: For each source, the insert and bypass gates are never on together. Neither bridge leg ever has both its gates on (bits 0 and 2, bits 1 and 3).
- R6: If the new pattern turns at least one gate off and at least one gate on, the outputs first show only the gates common to the old and new patterns. They hold that for dead_cycles+1 cycles, and only then show the new pattern. level_now updates together with the final pattern.
- R7: If a strobe needs no gate to go both off and on (for example, the same level again), the new pattern and level appear on the cycle after the strobe, with no gap.
- R8: Gate outputs and level_now change only as a result of a strobe. ref_smp changes without a strobe have no effect, and a strobe that arrives while a gap is pending is dropped.
- R9: While rst_n is low, src_ins=000, src_byp=111, hb_gate=0000 and level_now=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_vld | input | 1 | One-cycle strobe qualifying ref_smp |
| ref_smp | input | 16 | Signed reference sample |
| step_size | input | 16 | Unsigned size of one level step in reference units |
| dead_cycles | input | 8 | Gap length minus one, in cycles |
| src_ins | output | 3 | Source insert gates |
| src_byp | output | 3 | Source bypass gates |
| hb_gate | output | 4 | Polarity bridge gates |
| level_now | output | 4 | Signed level whose pattern is fully applied |

## Verification
The assertions assume that dead_cycles and step_size are held steady whenever a gap may be in progress, and that reset is asserted at least once before any clock edge is evaluated. The stimulus changes those two inputs only after each transition has fully settled. The bench pulses ref_vld for a single cycle, sets it up on the falling edge, and issues a strobe during a gap only in the one directed case that checks the strobe is dropped. Random samples cover the full signed 16-bit range, including the most negative code. Random step sizes run from very small, which forces saturation, to large, which keeps samples near zero.

// File: rtl/mli_pkg.sv
package mli_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_GAP  = 1'b1
  } seq_state_e;

  localparam logic [3:0] HB_OFF = 4'b0000;
  localparam logic [3:0] HB_POS = 4'b1001;
  localparam logic [3:0] HB_NEG = 4'b0110;

endpackage

// File: rtl/mli_quantizer.sv
module mli_quantizer #(
  parameter int REF_W  = 16,
  parameter int STEP_W = 16,
  parameter int N_SRC  = 3
) (
  input  logic signed [REF_W-1:0] smp,
  input  logic        [STEP_W-1:0] step,
  output logic signed [N_SRC:0]    lvl
);
  localparam int LVL_MAX = (1 << N_SRC) - 1;
  localparam int MAG_W   = REF_W + 1;
  localparam int CMP_W   = ((REF_W + 2) > (STEP_W + N_SRC + 2)) ? (REF_W + 2) : (STEP_W + N_SRC + 2);

  logic signed [MAG_W-1:0] ext;
  logic        [MAG_W-1:0] mag;
  logic        [CMP_W-1:0] dbl;
  logic        [LVL_MAX-1:0] hit;
  logic        [N_SRC-1:0] cnt;
  logic        [N_SRC:0]   mag_lvl;

  assign ext = {smp[REF_W-1], smp};
  assign mag = smp[REF_W-1] ? MAG_W'(-ext) : MAG_W'(ext);
  assign dbl = CMP_W'({mag, 1'b0});

  // one comparator per rounding threshold (odd multiples of half a step)
  for (genvar j = 0; j < LVL_MAX; j++) begin : g_thr
    localparam logic [CMP_W-1:0] ODD = CMP_W'(2 * j + 1);
    logic [CMP_W-1:0] thr;
    assign thr    = CMP_W'(step) * ODD;
    assign hit[j] = (dbl >= thr);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LVL_MAX; i++) begin
      cnt = cnt + N_SRC'(hit[i]);
    end
  end

  assign mag_lvl = {1'b0, cnt};
  assign lvl     = smp[REF_W-1] ? (N_SRC+1)'(-mag_lvl) : mag_lvl;

endmodule

// File: rtl/mli_gate_lut.sv
module mli_gate_lut
  import mli_pkg::*;
#(
  parameter int N_SRC = 3,
  localparam int GW   = 2 * N_SRC + 4
) (
  input  logic signed [N_SRC:0] lvl,
  output logic [GW-1:0]         gates
);
  logic [N_SRC-1:0] k;
  logic [N_SRC-1:0] ins;
  logic [N_SRC-1:0] byp;
  logic [3:0]       hb;

  assign k = N_SRC'(lvl[N_SRC] ? -lvl : lvl);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign ins[i] = k[i];
    assign byp[i] = ~k[i];
  end

  always_comb begin
    if (lvl[N_SRC])       hb = HB_NEG;
    else if (lvl == '0)   hb = HB_OFF;
    else                  hb = HB_POS;
  end

  assign gates = {hb, byp, ins};

endmodule

// File: rtl/mli_bbm_seq.sv
module mli_bbm_seq
  import mli_pkg::*;
#(
  parameter int N_SRC = 3,
  parameter int DT_W  = 8,
  localparam int GW   = 2 * N_SRC + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld,
  input  logic signed [N_SRC:0] tgt_lvl,
  input  logic [GW-1:0]         tgt_gates,
  input  logic [DT_W-1:0]       dead,
  output logic [GW-1:0]         gates,
  output logic signed [N_SRC:0] lvl
);
  localparam logic [GW-1:0] RST_GATES = {4'b0000, {N_SRC{1'b1}}, {N_SRC{1'b0}}};

  seq_state_e            st_q, st_d;
  logic [GW-1:0]         gates_q, gates_d;
  logic [GW-1:0]         pend_q, pend_d;
  logic signed [N_SRC:0] lvl_q, lvl_d;
  logic signed [N_SRC:0] plvl_q, plvl_d;
  logic [DT_W-1:0]       cnt_q, cnt_d;
  logic [GW-1:0]         brk, mk;

  assign brk = gates_q & ~tgt_gates;
  assign mk  = tgt_gates & ~gates_q;

  always_comb begin
    st_d    = st_q;
    gates_d = gates_q;
    pend_d  = pend_q;
    lvl_d   = lvl_q;
    plvl_d  = plvl_q;
    cnt_d   = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (vld) begin
          if ((|brk) && (|mk)) begin
            gates_d = gates_q & tgt_gates;
            pend_d  = tgt_gates;
            plvl_d  = tgt_lvl;
            cnt_d   = dead;
            st_d    = ST_GAP;
          end else begin
            gates_d = tgt_gates;
            lvl_d   = tgt_lvl;
          end
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          gates_d = pend_q;
          lvl_d   = plvl_q;
          st_d    = ST_IDLE;
        end else begin
          cnt_d = cnt_q - DT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      gates_q <= RST_GATES;
      pend_q  <= RST_GATES;
      lvl_q   <= '0;
      plvl_q  <= '0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      gates_q <= gates_d;
      pend_q  <= pend_d;
      lvl_q   <= lvl_d;
      plvl_q  <= plvl_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gates = gates_q;
  assign lvl   = lvl_q;

  // R5: per-source insert/bypass exclusion
  assert_src_interlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gates_q[N_SRC-1:0] & gates_q[2*N_SRC-1:N_SRC]) == '0);

  // R5: bridge leg exclusion
  assert_leg_interlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates_q[2*N_SRC] && gates_q[2*N_SRC+2]) && !(gates_q[2*N_SRC+1] && gates_q[2*N_SRC+3]));

  // R6: no cycle turns one gate on while turning another off
  assert_break_before_make_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(gates_q & ~$past(gates_q))) && (|(~gates_q & $past(gates_q)))));

  // R8: gate changes only follow a strobe or a pending gap
  assert_change_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gates_q != $past(gates_q)) |-> ($past(vld) || ($past(st_q) == ST_GAP)));

  // R2: the unused negative code never appears
  assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q != {1'b1, {N_SRC{1'b0}}});

  // R4: settled bridge state agrees with the reported sign
  assert_bridge_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !lvl_q[N_SRC] && lvl_q != '0) |-> (gates_q[GW-1:2*N_SRC] == HB_POS));

endmodule

// File: rtl/mli_gate_ctrl.sv
module mli_gate_ctrl #(
  parameter int REF_W  = 16,
  parameter int STEP_W = 16,
  parameter int N_SRC  = 3,
  parameter int DT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_vld,
  input  logic signed [REF_W-1:0] ref_smp,
  input  logic [STEP_W-1:0]       step_size,
  input  logic [DT_W-1:0]         dead_cycles,
  output logic [N_SRC-1:0]        src_ins,
  output logic [N_SRC-1:0]        src_byp,
  output logic [3:0]              hb_gate,
  output logic signed [N_SRC:0]   level_now
);
  localparam int GW = 2 * N_SRC + 4;

  logic signed [N_SRC:0] q_lvl;
  logic [GW-1:0]         q_gates;
  logic [GW-1:0]         gates;

  mli_quantizer #(.REF_W(REF_W), .STEP_W(STEP_W), .N_SRC(N_SRC)) u_quant (
    .smp  (ref_smp),
    .step (step_size),
    .lvl  (q_lvl)
  );

  mli_gate_lut #(.N_SRC(N_SRC)) u_lut (
    .lvl   (q_lvl),
    .gates (q_gates)
  );

  mli_bbm_seq #(.N_SRC(N_SRC), .DT_W(DT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (ref_vld),
    .tgt_lvl   (q_lvl),
    .tgt_gates (q_gates),
    .dead      (dead_cycles),
    .gates     (gates),
    .lvl       (level_now)
  );

  assign src_ins = gates[N_SRC-1:0];
  assign src_byp = gates[2*N_SRC-1:N_SRC];
  assign hb_gate = gates[GW-1:2*N_SRC];

endmodule

// File: tb/tb_mli_gate_ctrl.sv
module tb_mli_gate_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_vld;
  logic signed [15:0] ref_smp;
  logic [15:0] step_size;
  logic [7:0]  dead_cycles;
  logic [2:0]  src_ins, src_byp;
  logic [3:0]  hb_gate;
  logic signed [3:0] level_now;

  int checks = 0;
  int fails  = 0;
  logic [9:0]        cur_g;
  int                cur_l;

  always #(CLK_PERIOD/2) clk = ~clk;

  mli_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_vld(ref_vld), .ref_smp(ref_smp),
    .step_size(step_size), .dead_cycles(dead_cycles),
    .src_ins(src_ins), .src_byp(src_byp), .hb_gate(hb_gate), .level_now(level_now)
  );

  function automatic int quant(input int r, input int s);
    int m, q;
    m = (r < 0) ? -r : r;
    if (s == 0) q = 7;
    else q = (2 * m + s) / (2 * s);
    if (q > 7) q = 7;
    return (r < 0) ? -q : q;
  endfunction

  function automatic logic [9:0] pat(input int l);
    int k;
    logic [3:0] hb;
    k  = (l < 0) ? -l : l;
    hb = (l > 0) ? 4'b1001 : ((l < 0) ? 4'b0110 : 4'b0000);
    return {hb, ~3'(k), 3'(k)};
  endfunction

  task automatic check(input string tag, input logic [9:0] eg, input int el);
    logic [9:0] ag;
    ag = {hb_gate, src_byp, src_ins};
    checks++;
    if (ag !== eg || int'(level_now) != el) begin
      fails++;
      $display("FAIL %s: gates=%b level=%0d expected gates=%b level=%0d", tag, ag, level_now, eg, el);
    end
  endtask

  // strobe one sample and follow the expected sequence
  task automatic drive(input int r, input string tag);
    logic [9:0] tg, br, mk;
    int tl;
    tl = quant(r, int'(step_size));
    tg = pat(tl);
    br = cur_g & ~tg;
    mk = tg & ~cur_g;
    @(negedge clk);
    ref_vld = 1'b1;
    ref_smp = 16'(r);
    @(negedge clk);
    ref_vld = 1'b0;
    if (br != 0 && mk != 0) begin
      check("R6 gap", cur_g & tg, cur_l);
      for (int i = 0; i < int'(dead_cycles); i++) begin
        @(negedge clk);
        check("R6 hold", cur_g & tg, cur_l);
      end
      @(negedge clk);
    end
    check(tag, tg, tl);
    cur_g = tg;
    cur_l = tl;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run expired, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    rst_n = 1'b0; ref_vld = 1'b0; ref_smp = '0; step_size = 16'd100; dead_cycles = 8'd2;
    repeat (3) @(negedge clk);
    check("R9 reset", 10'b0000111000, 0);
    rst_n = 1'b1;
    cur_g = 10'b0000111000; cur_l = 0;

    // R7: same level again, no gap
    drive(10, "R7 same level");
    // R1 ties and rounding
    drive(150, "R1 tie up to 2");
    drive(149, "R1 below tie");
    drive(-150, "R1 negative tie");
    drive(-50, "R1 negative half");
    drive(49, "R1 toward zero");
    drive(700, "R3 magnitude 7");
    drive(-700, "R4 polarity flip");
    drive(-32768, "R2 saturate negative");
    drive(32767, "R2 saturate positive");
    dead_cycles = 8'd0;
    drive(300, "R6 zero dead time");
    step_size = 16'd0;
    drive(0, "R1 zero step");
    step_size = 16'd100;

    // R8: sample change without strobe
    @(negedge clk); ref_smp = -16'sd400;
    repeat (3) @(negedge clk);
    check("R8 no strobe", cur_g, cur_l);

    // R8: strobe during a pending gap is dropped
    dead_cycles = 8'd4;
    @(negedge clk); ref_vld = 1'b1; ref_smp = 16'sd200;
    @(negedge clk); ref_smp = -16'sd500;
    check("R6 gap entered", cur_g & pat(2), cur_l);
    @(negedge clk); ref_vld = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 dropped strobe", pat(2), 2);
    repeat (3) @(negedge clk);
    check("R8 still settled", pat(2), 2);
    cur_g = pat(2); cur_l = 2;

    // random mix
    for (int n = 0; n < 300; n++) begin
      step_size   = 16'(($urandom % 4000) + 1);
      dead_cycles = 8'($urandom % 6);
      drive(int'($signed(16'($urandom))), "R1 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule